// File: doc/BRIEF.md
# ECC Quadword Datapath with Scrub Write-Back

This block sits between a 64-bit host request port and a 72-bit storage port. On every write where protection applies, it computes eight check bits for the quadword and stores them beside the data. On every read it recomputes them, decodes the syndrome, and reports single-bit and double-bit errors. Each error report is a one-cycle pulse carrying the failing address, sent to an external error logger.

A 2-bit integrity mode selects the behaviour:
- `00` turns protection off.
- `01` detects and reports errors but corrects nothing.
- `10` corrects single-bit errors.
- `11` also writes the corrected word back to storage.

A per-row mask marks storage rows that hold no check bits. Such rows are treated as unprotected whatever the mode. A host write with a deasserted byte enable, on a protected row, becomes a read-merge-write. During that sequence the host port is held off through its ready signal.

Storage is a synchronous memory with a 9-lane write mask: eight data byte lanes plus one check-bit lane. Read data appears the cycle after the read is issued. The host must only change the mode while `req_ready_o` is high.

Top module: `ecc_scrub_path`

## Requirements
- R1: A full write (all byte enables set) to a protected row (mode not `00`, row bit in `row_noecc_i` clear) stores `{chk, data}` with all 9 write lanes enabled. The check byte is defined as follows. Codeword positions 1 to 71 exclude the powers of two, and data bits 0 to 63 fill the remaining positions in ascending order. Check bit k (k = 0 to 6) is the XOR of the data bits whose position has bit k set. Check bit 7 makes the XOR of all 72 stored bits zero.
- R2: In mode `00`, a write enables only the data lanes whose byte enable is set and never the check lane (mask bit 8). A read returns the stored 64 data bits unchanged and raises no error pulse.
- R3: In mode `01`, a read of a word with one flipped bit raises `err_sbe_o`, and a read with two flipped bits raises `err_mbe_o`. In both cases the raw stored data is returned.
- R4: In modes `10` and `11`, a read of a word with one flipped data bit returns the corrected data. The same cycle carries an `err_sbe_o` pulse with `err_addr_o` equal to the request address.
- R5: A read of a word with two flipped bits raises `err_mbe_o` but not `err_sbe_o`, and returns the stored data unmodified.
- R6: In mode `11`, a corrected read issues, in the cycle the response is given, a 9-lane write of the corrected word with fresh check bits to the same address. Mode `10` performs no such write-back.
- R7: With protection active, a write with any byte enable clear first reads the word. It then writes the merge of the new enabled bytes and the old, corrected bytes, with recomputed check bits. `req_ready_o` stays low during the merge cycle.
- R8: Reads from a row whose `row_noecc_i` bit is set return raw data with no error pulse. Writes to such a row leave the check lane unwritten.
- R9: After reset, `req_ready_o` is high and no response, error or storage access is active. A read accepted at one clock edge gives `rsp_valid_o` for exactly the following cycle, with `req_ready_o` low in that cycle.
- R10: A flip of only the overall parity bit (stored bit 71) is reported as a single-bit error, and the data is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| row_noecc_i | input | 2**ROW_BITS | Per-row flag, 1 = row holds no check bits |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Quadword address; top ROW_BITS bits select the row |
| req_be_i | input | 8 | Byte enables for writes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid (one cycle) |
| rsp_rdata_o | output | 64 | Read data |
| mem_en_o | output | 1 | Storage access enable |
| mem_we_o | output | 1 | Storage write (else read) |
| mem_addr_o | output | ADDR_W | Storage address |
| mem_be_o | output | 9 | Storage write lanes: bits 7:0 data bytes, bit 8 check byte |
| mem_wdata_o | output | 72 | Storage write word {check[7:0], data[63:0]} |
| mem_rdata_i | input | 72 | Storage read word, valid the cycle after a read |
| err_sbe_o | output | 1 | Single-bit error pulse |
| err_mbe_o | output | 1 | Multi-bit error pulse |
| err_addr_o | output | ADDR_W | Address of the reported error |

## Verification
The decoder is tried with a clean word, a single flipped data bit, a flipped overall parity bit and two flipped data bits. Together these separate the clean, correctable, parity-only and uncorrectable syndrome classes.

The same single-bit flip is repeated in modes `01`, `10` and `11`. This distinguishes report-only, correct-only and correct-plus-write-back, where the storage contents after the read expose whether a scrub happened.

Partial writes are driven both onto a clean word and onto a word with a flipped bit in an unwritten byte, which shows that the merge uses corrected old data. The same partial write is then repeated in mode `00` and on an unprotected row, which shows that these paths bypass the merge and the check lane.

// File: rtl/ecc_scrub_path.sv
module ecc_scrub_path #(
  parameter int ADDR_W   = 10,
  parameter int ROW_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_i,
  input  logic [(1<<ROW_BITS)-1:0]   row_noecc_i,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [7:0]                 req_be_i,
  input  logic [63:0]                req_wdata_i,
  output logic                       rsp_valid_o,
  output logic [63:0]                rsp_rdata_o,
  output logic                       mem_en_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [8:0]                 mem_be_o,
  output logic [71:0]                mem_wdata_o,
  input  logic [71:0]                mem_rdata_i,
  output logic                       err_sbe_o,
  output logic                       err_mbe_o,
  output logic [ADDR_W-1:0]          err_addr_o
);

  localparam int ROWS = 1 << ROW_BITS;

  function automatic logic [7:0] chk_gen(input logic [63:0] d);
    logic [6:0] h;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[j]) h = h ^ p[6:0];
        j++;
      end
    end
    return {^{d, h}, h};
  endfunction

  function automatic logic [63:0] flip_at(input logic [63:0] d, input logic [6:0] syn);
    logic [63:0] r;
    int j;
    r = d;
    j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p[6:0] == syn) r[j] = ~r[j];
        j++;
      end
    end
    return r;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RMW} state_t;
  state_t state;

  logic [ADDR_W-1:0] q_addr;
  logic [63:0]       q_wdata;
  logic [7:0]        q_be;

  logic accept, ecc_in, ecc_q, partial;
  assign accept  = req_valid_i && state == S_IDLE;
  assign partial = ~&req_be_i;
  assign ecc_in  = mode_i != 2'b00 && !row_noecc_i[req_addr_i[ADDR_W-1 -: ROW_BITS]];
  assign ecc_q   = mode_i != 2'b00 && !row_noecc_i[q_addr[ADDR_W-1 -: ROW_BITS]];

  logic [63:0] rd_d, fixed_d, good_d, merged_d;
  logic [7:0]  rd_c, calc_c;
  logic [6:0]  syn;
  logic        odd, check_on, hit_sbe, hit_mbe, use_fix, scrub;

  assign rd_d     = mem_rdata_i[63:0];
  assign rd_c     = mem_rdata_i[71:64];
  assign calc_c   = chk_gen(rd_d);
  assign syn      = calc_c[6:0] ^ rd_c[6:0];
  assign odd      = ^mem_rdata_i;
  assign fixed_d  = flip_at(rd_d, syn);
  assign check_on = state != S_IDLE && ecc_q;
  assign hit_sbe  = check_on && odd;
  assign hit_mbe  = check_on && !odd && syn != '0;
  assign use_fix  = hit_sbe && mode_i[1];
  assign good_d   = use_fix ? fixed_d : rd_d;
  assign scrub    = state == S_RD && use_fix && mode_i == 2'b11;

  always_comb begin
    for (int b = 0; b < 8; b++)
      merged_d[8*b +: 8] = q_be[b] ? q_wdata[8*b +: 8] : good_d[8*b +: 8];
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = req_addr_i;
    mem_be_o    = '0;
    mem_wdata_o = {8'h00, req_wdata_i};
    if (accept) begin
      mem_en_o = 1'b1;
      if (req_write_i && !(ecc_in && partial)) begin
        mem_we_o    = 1'b1;
        mem_be_o    = ecc_in ? 9'h1FF : {1'b0, req_be_i};
        mem_wdata_o = {ecc_in ? chk_gen(req_wdata_i) : 8'h00, req_wdata_i};
      end
    end else if (scrub) begin
      mem_en_o    = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = q_addr;
      mem_be_o    = 9'h1FF;
      mem_wdata_o = {chk_gen(good_d), good_d};
    end else if (state == S_RMW) begin
      mem_en_o    = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = q_addr;
      mem_be_o    = 9'h1FF;
      mem_wdata_o = {chk_gen(merged_d), merged_d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q_addr  <= '0;
      q_wdata <= '0;
      q_be    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          q_addr  <= req_addr_i;
          q_wdata <= req_wdata_i;
          q_be    <= req_be_i;
          if (!req_write_i)          state <= S_RD;
          else if (ecc_in && partial) state <= S_RMW;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = state == S_IDLE;
  assign rsp_valid_o = state == S_RD;
  assign rsp_rdata_o = good_d;
  assign err_sbe_o   = hit_sbe;
  assign err_mbe_o   = hit_mbe;
  assign err_addr_o  = q_addr;

  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_write_i) |=> (rsp_valid_o && !req_ready_o));

  a_r9_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  a_r7_merge_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_write_i && ecc_in && partial)
      |=> (mem_en_o && mem_we_o && mem_be_o == 9'h1FF && mem_addr_o == $past(req_addr_i)));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_sbe_o && err_mbe_o));

  a_r6_no_scrub_low_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && mode_i != 2'b11) |-> !(mem_en_o && mem_we_o));

  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !(err_sbe_o || err_mbe_o));

  initial assert (ROWS >= 2 && ROW_BITS < ADDR_W);

endmodule

// File: tb/tb_ecc_scrub_path.sv
module tb_ecc_scrub_path;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int RB = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b10;
  logic [(1<<RB)-1:0] noecc = 8'b0010_0000;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_be = 8'hFF;
  logic [63:0] req_wdata = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [8:0] mem_be;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata = '0;
  logic err_sbe, err_mbe;
  logic [AW-1:0] err_addr;

  logic [71:0] store [0:(1<<AW)-1];
  logic inj_en = 0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_mask = '0;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_scrub_path #(.ADDR_W(AW), .ROW_BITS(RB)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .row_noecc_i(noecc),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .err_sbe_o(err_sbe), .err_mbe_o(err_mbe), .err_addr_o(err_addr));

  initial for (int i = 0; i < (1<<AW); i++) store[i] = '0;

  always @(posedge clk) begin
    if (inj_en) store[inj_addr] <= store[inj_addr] ^ inj_mask;
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 9; l++)
          if (mem_be[l]) store[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= store[mem_addr];
      end
    end
  end

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [6:0] c;
    int pos;
    c = '0;
    pos = 0;
    for (int i = 0; i < 64; i++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 7; k++) if ((pos >> k) & 1) c[k] = c[k] ^ d[i];
    end
    return {(^d) ^ (^c), c};
  endfunction

  task automatic check(input logic ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_addr = a; inj_mask = m; inj_en = 1;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
  endtask

  logic [63:0] r_data;
  logic r_valid, r_sbe, r_mbe, r_wb;
  logic [AW-1:0] r_eaddr;

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    r_valid = rsp_valid; r_data = rsp_rdata; r_sbe = err_sbe; r_mbe = err_mbe;
    r_eaddr = err_addr; r_wb = mem_en && mem_we && mem_addr == a && mem_be == 9'h1FF;
    check(!req_ready, "R9 ready low in response cycle", {71'd0, req_ready}, 72'd0);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    check(req_ready && !rsp_valid && !err_sbe && !err_mbe && !mem_en, "R9 reset state",
          {67'd0, req_ready, rsp_valid, err_sbe, err_mbe, mem_en}, 72'h10);
  endtask

  task automatic t_full_write();
    logic [63:0] d = 64'hDEAD_BEEF_0123_4567;
    mode = 2'b10;
    do_write(10'd3, d, 8'hFF);
    check(store[3] == {enc(d), d}, "R1 stored word", store[3], {enc(d), d});
    do_read(10'd3);
    check(r_valid && r_data == d, "R9 clean read", {8'd0, r_data}, {8'd0, d});
    check(!r_sbe && !r_mbe, "R1 clean read no error", {70'd0, r_sbe, r_mbe}, 72'd0);
  endtask

  task automatic t_single_fix();
    logic [63:0] d = 64'hDEAD_BEEF_0123_4567;
    mode = 2'b10;
    inject(10'd3, 72'd1 << 17);
    do_read(10'd3);
    check(r_data == d, "R4 corrected data", {8'd0, r_data}, {8'd0, d});
    check(r_sbe && !r_mbe && r_eaddr == 10'd3, "R4 sbe pulse and address",
          {60'd0, r_sbe, r_mbe, r_eaddr}, {60'd0, 2'b10, 10'd3});
    check(!r_wb && store[3] == ({enc(d), d} ^ (72'd1 << 17)), "R6 no write-back in mode 10",
          store[3], {enc(d), d} ^ (72'd1 << 17));
    inject(10'd3, 72'd1 << 17);
  endtask

  task automatic t_parity_bit();
    logic [63:0] d = 64'h0F0F_1234_AAAA_5555;
    mode = 2'b10;
    do_write(10'd4, d, 8'hFF);
    inject(10'd4, 72'd1 << 71);
    do_read(10'd4);
    check(r_data == d && r_sbe && !r_mbe, "R10 parity-bit flip is single",
          {6'd0, r_sbe, r_mbe, r_data}, {6'd0, 2'b10, d});
  endtask

  task automatic t_double();
    logic [63:0] d = 64'h1111_2222_3333_4444;
    logic [71:0] m = (72'd1 << 5) | (72'd1 << 40);
    mode = 2'b10;
    do_write(10'd6, d, 8'hFF);
    inject(10'd6, m);
    do_read(10'd6);
    check(r_mbe && !r_sbe, "R5 mbe only", {70'd0, r_sbe, r_mbe}, 72'd1);
    check(r_data == (d ^ m[63:0]), "R5 data unmodified", {8'd0, r_data}, {8'd0, d ^ m[63:0]});
  endtask

  task automatic t_detect();
    logic [63:0] d = 64'hCAFE_F00D_8765_4321;
    mode = 2'b01;
    do_write(10'd7, d, 8'hFF);
    check(store[7] == {enc(d), d}, "R1 check bits in detect mode", store[7], {enc(d), d});
    inject(10'd7, 72'd1 << 50);
    do_read(10'd7);
    check(r_sbe && !r_mbe && r_data == (d ^ (64'd1 << 50)), "R3 single reported, raw data",
          {6'd0, r_sbe, r_mbe, r_data}, {6'd0, 2'b10, d ^ (64'd1 << 50)});
    inject(10'd7, 72'd1 << 2);
    do_read(10'd7);
    check(r_mbe && !r_sbe, "R3 double reported", {70'd0, r_sbe, r_mbe}, 72'd1);
  endtask

  task automatic t_scrub();
    logic [63:0] d = 64'h0123_4567_89AB_CDEF;
    mode = 2'b11;
    do_write(10'd9, d, 8'hFF);
    inject(10'd9, 72'd1 << 33);
    do_read(10'd9);
    check(r_data == d && r_sbe, "R4 corrected in scrub mode", {8'd0, r_data}, {8'd0, d});
    check(r_wb, "R6 write-back issued", {71'd0, r_wb}, 72'd1);
    check(store[9] == {enc(d), d}, "R6 storage repaired", store[9], {enc(d), d});
    do_read(10'd9);
    check(!r_sbe && !r_mbe && !r_wb, "R6 clean after scrub", {69'd0, r_sbe, r_mbe, r_wb}, 72'd0);
  endtask

  task automatic t_partial();
    logic [63:0] d = 64'hAAAA_BBBB_CCCC_DDDD;
    logic [63:0] n = 64'h1234_5678_9ABC_DEF0;
    logic [63:0] m = {d[63:32], n[31:0]};
    mode = 2'b10;
    do_write(10'd12, d, 8'hFF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'd12; req_wdata = n; req_be = 8'h0F;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R7 ready low during merge", {71'd0, req_ready}, 72'd0);
    while (!req_ready) @(negedge clk);
    check(store[12] == {enc(m), m}, "R7 merged word", store[12], {enc(m), m});
    inject(10'd12, 72'd1 << 60);
    do_write(10'd12, 64'h0, 8'h01);
    m[7:0] = 8'h00;
    check(store[12] == {enc(m), m}, "R7 merge uses corrected data", store[12], {enc(m), m});
  endtask

  task automatic t_passthrough();
    logic [63:0] d = 64'h5555_6666_7777_8888;
    logic [63:0] n = 64'h9999_AAAA_BBBB_CCCC;
    logic [63:0] m = {d[63:32], n[31:0]};
    mode = 2'b10;
    do_write(10'd14, d, 8'hFF);
    mode = 2'b00;
    do_write(10'd14, n, 8'h0F);
    check(store[14] == {enc(d), m}, "R2 lane write, check lane kept", store[14], {enc(d), m});
    inject(10'd14, 72'd1 << 20);
    do_read(10'd14);
    check(r_data == (m ^ (64'd1 << 20)) && !r_sbe && !r_mbe, "R2 raw read, no error",
          {6'd0, r_sbe, r_mbe, r_data}, {8'd0, m ^ (64'd1 << 20)});
  endtask

  task automatic t_noecc_row();
    logic [63:0] d = 64'h7E7E_1818_3C3C_0101;
    mode = 2'b10;
    do_write(10'h285, d, 8'hFF);
    check(store[10'h285] == {8'h00, d}, "R8 check lane untouched", store[10'h285], {8'h00, d});
    inject(10'h285, 72'd1 << 9);
    do_read(10'h285);
    check(r_data == (d ^ (64'd1 << 9)) && !r_sbe && !r_mbe, "R8 raw read, no error",
          {6'd0, r_sbe, r_mbe, r_data}, {8'd0, d ^ (64'd1 << 9)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full_write();
    t_single_fix();
    t_parity_bit();
    t_double();
    t_detect();
    t_scrub();
    t_partial();
    t_passthrough();
    t_noecc_row();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule